// File: doc/BRIEF.md
# Prescaled Up-Counter Time Base

This block is the time base of a general-purpose timer. A programmable divider turns the system clock into counting ticks. On each tick an up-counter steps forward, and it wraps to zero when it reaches a reload limit. One compare channel compares the counter against a compare value and drives a pulse-width output. That output can be gated off and can have its sense inverted.

Software writes the counter, the divider value, the reload limit and the compare value through a single write port. The divider value and the reload limit are double-buffered. A write lands in a holding register, and it reaches the active copy only at an update event. An update event is either the natural wrap of the counter or a forced update request. A new period or rate therefore always starts cleanly at a period boundary. The active reload limit resets to zero, and the counter does not move while that limit is zero. After reset, software loads the holding registers and then forces an update to start the timer.

Top module: `tbase_core`

## Requirements
- R1: After reset the counter output is 0, the update pulse is low, and the active divider value and active reload limit are both 0.
- R2: While the active reload limit is nonzero, the counter advances by one once every (active divider value + 1) clocks.
- R3: A write with select code 1 sets the divider holding register. The active divider value changes only at an update event, and it then takes the holding value from before that cycle.
- R4: A write with select code 2 sets the reload holding register. The active reload limit changes only at an update event, and it then takes the holding value from before that cycle.
- R5: While the active reload limit is 0, the counter holds its value unless it is written or a forced update occurs.
- R6: When the channel enable input is 0, the compare output is 0.
- R7: When the channel enable input is 1, the compare output is (counter < compare value) XOR polarity. A write with select code 3 sets the compare value, and the new value takes effect from the next clock.
- R8: When a tick finds the counter equal to a nonzero active reload limit, the update pulse is high in that cycle. The counter is 0 on the next clock, and the divider restarts its count from 0.
- R9: A forced update request raises the update pulse in the same cycle. On the next clock the counter and the divider count are 0 and both active copies are reloaded. A forced update takes priority over a counter write.
- R10: A write with select code 0 loads the counter on the next clock. That write suppresses a natural wrap in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 counter, 1 divider, 2 reload, 3 compare |
| wr_data_i | input | W (16) | Write data |
| force_upd_i | input | 1 | Forced update request |
| ch_en_i | input | 1 | Compare channel enable |
| ch_pol_i | input | 1 | Compare output inversion |
| count_o | output | W (16) | Counter value |
| upd_o | output | 1 | One-cycle update event pulse |
| cmp_o | output | 1 | Gated compare output |

## Verification
The assertions assume that the inputs change only between clock edges. They also take the write select as a clean two-bit code that is sampled only while the strobe is high. A forced update and a counter write in the same cycle are treated as defined, with the forced update taking priority. The stimulus drives every input on the falling edge and lowers each strobe after one cycle. The bench does load holding registers while the counter is running, which checks that those writes are deferred until the next period boundary.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
   typedef enum logic [1:0] {
      SEL_COUNT   = 2'd0,
      SEL_DIVIDER = 2'd1,
      SEL_RELOAD  = 2'd2,
      SEL_COMPARE = 2'd3
   } wr_sel_e;
endpackage

// File: rtl/tbase_divider.sv
module tbase_divider #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_hold_i,
   input  logic [W-1:0] wr_data_i,
   input  logic         upd_i,
   output logic         tick_o,
   output logic [W-1:0] hold_o,
   output logic [W-1:0] active_o
);
   logic [W-1:0] div_cnt;

   assign tick_o = (div_cnt == active_o);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         div_cnt  <= '0;
         hold_o   <= '0;
         active_o <= '0;
      end else begin
         if (wr_hold_i) hold_o <= wr_data_i;
         if (upd_i) active_o <= hold_o;
         if (upd_i || tick_o) div_cnt <= '0;
         else                 div_cnt <= div_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_hold_i,
   input  logic         wr_count_i,
   input  logic [W-1:0] wr_data_i,
   input  logic         tick_i,
   input  logic         force_i,
   input  logic         upd_i,
   output logic         wrap_o,
   output logic [W-1:0] count_o,
   output logic [W-1:0] hold_o,
   output logic [W-1:0] active_o
);
   logic running;

   assign running = (active_o != '0);
   assign wrap_o  = tick_i && running && (count_o == active_o) && !wr_count_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         count_o  <= '0;
         hold_o   <= '0;
         active_o <= '0;
      end else begin
         if (wr_hold_i) hold_o <= wr_data_i;
         if (upd_i) active_o <= hold_o;
         if (force_i)                 count_o <= '0;
         else if (wr_count_i)         count_o <= wr_data_i;
         else if (running && tick_i)  count_o <= wrap_o ? '0 : count_o + 1'b1;
      end
   end
endmodule

// File: rtl/tbase_compare.sv
module tbase_compare #(
   parameter int W = 16
) (
   input  logic [W-1:0] count_i,
   input  logic [W-1:0] cmp_val_i,
   input  logic         en_i,
   input  logic         pol_i,
   output logic         out_o
);
   logic ref_lvl;

   assign ref_lvl = (count_i < cmp_val_i);
   assign out_o   = en_i & (ref_lvl ^ pol_i);
endmodule

// File: rtl/tbase_core.sv
module tbase_core #(
   parameter int W       = 16,
   parameter bit CMP_REG = 1'b0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_en_i,
   input  logic [1:0]   wr_sel_i,
   input  logic [W-1:0] wr_data_i,
   input  logic         force_upd_i,
   input  logic         ch_en_i,
   input  logic         ch_pol_i,
   output logic [W-1:0] count_o,
   output logic         upd_o,
   output logic         cmp_o
);
   import tbase_pkg::*;

   localparam int MinW = 2;
   localparam int MaxW = 32;

   if (W < MinW || W > MaxW) begin : g_bad_width
      $error("tbase_core: W must lie in 2..32");
   end

   logic         wr_count, wr_div, wr_reload, wr_cmp;
   logic         tick, wrap;
   logic [W-1:0] psc_pre, psc_act, arr_pre, arr_act;
   logic [W-1:0] cmp_val;
   logic         cmp_comb;

   assign wr_count  = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_COUNT);
   assign wr_div    = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_DIVIDER);
   assign wr_reload = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_RELOAD);
   assign wr_cmp    = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_COMPARE);

   assign upd_o = force_upd_i || wrap;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     cmp_val <= '0;
      else if (wr_cmp) cmp_val <= wr_data_i;
   end

   tbase_divider #(.W(W)) u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_hold_i (wr_div),
      .wr_data_i (wr_data_i),
      .upd_i     (upd_o),
      .tick_o    (tick),
      .hold_o    (psc_pre),
      .active_o  (psc_act)
   );

   tbase_counter #(.W(W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_hold_i  (wr_reload),
      .wr_count_i (wr_count),
      .wr_data_i  (wr_data_i),
      .tick_i     (tick),
      .force_i    (force_upd_i),
      .upd_i      (upd_o),
      .wrap_o     (wrap),
      .count_o    (count_o),
      .hold_o     (arr_pre),
      .active_o   (arr_act)
   );

   tbase_compare #(.W(W)) u_cmp (
      .count_i   (count_o),
      .cmp_val_i (cmp_val),
      .en_i      (ch_en_i),
      .pol_i     (ch_pol_i),
      .out_o     (cmp_comb)
   );

   if (CMP_REG) begin : g_cmp_reg
      always_ff @(posedge clk_i) begin
         if (!rst_ni) cmp_o <= 1'b0;
         else         cmp_o <= cmp_comb;
      end
   end else begin : g_cmp_comb
      assign cmp_o = cmp_comb;
   end
endmodule

// File: rtl/tbase_core_chk.sv
module tbase_core_chk #(
   parameter int W       = 16,
   parameter bit CMP_REG = 1'b0
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         wr_en_i,
   input logic [1:0]   wr_sel_i,
   input logic [W-1:0] wr_data_i,
   input logic         force_upd_i,
   input logic         ch_en_i,
   input logic [W-1:0] count_o,
   input logic         upd_o,
   input logic         cmp_o,
   input logic [W-1:0] psc_pre,
   input logic [W-1:0] psc_act,
   input logic [W-1:0] arr_pre,
   input logic [W-1:0] arr_act
);
   logic cnt_wr;
   assign cnt_wr = wr_en_i && (wr_sel_i == 2'd0);

   p_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arr_act == '0 && !force_upd_i && !cnt_wr) |=> $stable(count_o));

   p_force_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_upd_i |-> upd_o);

   p_force_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_upd_i |=> (count_o == '0));

   p_wrap_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_o && !cnt_wr) |=> (count_o == '0));

   p_psc_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_o |=> (psc_act == $past(psc_pre)));

   p_psc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !upd_o |=> $stable(psc_act));

   p_arr_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_o |=> (arr_act == $past(arr_pre)));

   p_arr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !upd_o |=> $stable(arr_act));

   p_cnt_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_wr && !force_upd_i) |=> (count_o == $past(wr_data_i)));

   if (!CMP_REG) begin : g_comb_chk
      p_gate_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !ch_en_i |-> !cmp_o);
   end
endmodule

bind tbase_core tbase_core_chk #(.W(W), .CMP_REG(CMP_REG)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .wr_en_i     (wr_en_i),
   .wr_sel_i    (wr_sel_i),
   .wr_data_i   (wr_data_i),
   .force_upd_i (force_upd_i),
   .ch_en_i     (ch_en_i),
   .count_o     (count_o),
   .upd_o       (upd_o),
   .cmp_o       (cmp_o),
   .psc_pre     (psc_pre),
   .psc_act     (psc_act),
   .arr_pre     (arr_pre),
   .arr_act     (arr_act)
);

// File: tb/tbase_core_tb_top.sv
`timescale 1ns/1ps
module tbase_core_tb_top;
   localparam int W = 16;

   typedef struct {
      logic [W-1:0] cnt;
      logic         upd;
      logic         cmp;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = 2'd0;
   logic [W-1:0] wr_data = '0;
   logic         force_upd = 1'b0;
   logic         ch_en = 1'b0;
   logic         ch_pol = 1'b0;
   logic [W-1:0] count;
   logic         upd;
   logic         cmp;

   int checks = 0;
   int errors = 0;
   int upd_seen = 0;
   exp_t q[$];

   logic [W-1:0] m_cnt = '0, m_pc = '0, m_psc_act = '0, m_arr_act = '0;
   logic [W-1:0] m_psc_pre = '0, m_arr_pre = '0, m_cmp = '0;

   always #4 clk = ~clk;

   tbase_core #(.W(W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
      .wr_data_i(wr_data), .force_upd_i(force_upd), .ch_en_i(ch_en),
      .ch_pol_i(ch_pol), .count_o(count), .upd_o(upd), .cmp_o(cmp)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: compares each queued expectation against the ports
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " count"}, count, e.cnt);
            check({e.tag, " upd"}, {15'd0, upd}, {15'd0, e.upd});
            check({e.tag, " cmp"}, {15'd0, cmp}, {15'd0, e.cmp});
         end
      end
   end

   // driver: one clock of stimulus; predicts this cycle's outputs, then advances the model
   task automatic cyc(input string tag, input logic we, input logic [1:0] ws,
                      input logic [W-1:0] wd, input logic fu);
      logic tick, wrap, u, cw;
      exp_t e;
      @(negedge clk);
      wr_en = we; wr_sel = ws; wr_data = wd; force_upd = fu;
      #1;
      cw   = we && ws == 2'd0;
      tick = (m_pc == m_psc_act);
      wrap = tick && m_arr_act != '0 && m_cnt == m_arr_act && !cw;
      u    = fu || wrap;
      e.cnt = m_cnt; e.upd = u; e.tag = tag;
      e.cmp = ch_en && ((m_cnt < m_cmp) ^ ch_pol);
      q.push_back(e);
      @(posedge clk);
      if (u) upd_seen++;
      if (fu)                                 m_cnt = '0;
      else if (cw)                            m_cnt = wd;
      else if (m_arr_act != '0 && tick)       m_cnt = wrap ? '0 : m_cnt + 1'b1;
      m_pc = (u || tick) ? '0 : m_pc + 1'b1;
      if (u) begin m_psc_act = m_psc_pre; m_arr_act = m_arr_pre; end
      if (we && ws == 2'd1) m_psc_pre = wd;
      if (we && ws == 2'd2) m_arr_pre = wd;
      if (we && ws == 2'd3) m_cmp = wd;
   endtask

   task automatic idle(input string tag, input int n);
      for (int i = 0; i < n; i++) cyc(tag, 1'b0, 2'd0, '0, 1'b0);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 count at reset", count, '0);
      check("R1 upd at reset", {15'd0, upd}, '0);
      @(negedge clk);
      rst_n = 1'b1;
      // R5: active reload is 0 after reset, counter frozen
      idle("R5 stall after reset", 6);
      check("R5 count frozen", count, '0);
      // R3 R4: holding writes have no effect before an update
      cyc("R3 divider hold", 1'b1, 2'd1, 16'd2, 1'b0);
      cyc("R4 reload hold", 1'b1, 2'd2, 16'd3, 1'b0);
      idle("R4 no effect yet", 6);
      check("R4 still frozen", count, '0);
      // R9: forced update starts the time base
      cyc("R9 force", 1'b0, 2'd0, '0, 1'b1);
      upd_seen = 0;
      // R2 R8: divider 2, reload 3 -> one wrap every 12 clocks
      idle("R2 R8 free run", 24);
      check("R8 wraps in 24 clocks", upd_seen[W-1:0], 16'd2);
      // R3 R4: new values deferred until next wrap
      cyc("R3 divider change", 1'b1, 2'd1, 16'd0, 1'b0);
      cyc("R4 reload change", 1'b1, 2'd2, 16'd5, 1'b0);
      idle("R3 R4 deferred", 30);
      // R7: compare channel
      ch_en = 1'b1;
      cyc("R7 compare value", 1'b1, 2'd3, 16'd2, 1'b0);
      idle("R7 pol0", 14);
      ch_pol = 1'b1;
      idle("R7 pol1", 14);
      // R6: gated off
      ch_en = 1'b0;
      idle("R6 gate off", 10);
      // R10: counter write, including on a wrap cycle
      cyc("R10 count write", 1'b1, 2'd0, 16'd4, 1'b0);
      idle("R10 after write", 3);
      cyc("R10 write at limit", 1'b1, 2'd0, 16'd5, 1'b0);
      cyc("R10 write blocks wrap", 1'b1, 2'd0, 16'd5, 1'b0);
      idle("R10 resume", 4);
      // R9: force beats a counter write
      cyc("R9 force over write", 1'b1, 2'd0, 16'd9, 1'b1);
      idle("R9 after", 4);
      // R5: reload 0 loaded at forced update stops the counter
      cyc("R5 reload zero", 1'b1, 2'd2, 16'd0, 1'b0);
      cyc("R5 force", 1'b0, 2'd0, '0, 1'b1);
      cyc("R5 write while stalled", 1'b1, 2'd0, 16'd7, 1'b0);
      idle("R5 stalled", 10);
      check("R5 held value", count, 16'd7);
      @(negedge clk);
      #3;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule